// File: doc/BRIEF.md
# Relative Countdown Alarm

This block is a one-shot alarm timer. Software does not program an absolute wake-up time. It loads an interval, split into days, hours, minutes and seconds, and the block counts that interval down by one second on every pulse of a 1 Hz tick. Counting happens only while the alarm is switched on. When the interval runs out, a sticky pending flag is raised. That flag drives an interrupt line if interrupts are allowed.

Four word registers sit on a simple single-cycle memory-mapped bus. The first holds the remaining interval, and reading it always returns what is left. The second is the on/off switch for counting. The third allows the interrupt. The fourth holds the pending flag, which is cleared by writing a one to it. A typical sequence has four steps. Software turns both enables off and writes zero to the interval. It then loads the new interval, switches the counter and the interrupt back on, and clears the flag from the interrupt handler.

Top module: `rel_alarm`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: The interval register sits at byte offset 0x0C and is read and written in place. Seconds are in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21, with up to 255 days. All other bits read as zero.
- R3: The interval changes only on a cycle where `tick_1hz` is high and the run bit is set. Ticks while the run bit is clear, and cycles without a tick, leave it unchanged.
- R4: One tick removes one second, with borrows. Zero seconds reload to 59 and take one minute. Zero minutes reload to 59 and take one hour. Zero hours reload to 23 and take one day.
- R5: The tick that brings a nonzero interval to zero sets the pending flag, which is bit 0 of the status register at offset 0x1C. No earlier tick sets it.
- R6: An interval of zero stays at zero under further ticks, and it never sets the pending flag again until a new nonzero interval has been loaded.
- R7: Writing a 1 to status bit 0 clears the pending flag. Writing 0 leaves it as it was.
- R8: `irq` is high exactly when the pending flag is set and bit 0 of the interrupt-enable register at offset 0x18 is set.
- R9: Writing zero to the interval register cancels a running countdown, so no expiry follows.
- R10: A write to the interval register in the same cycle as a counted tick loads the written value, and the tick is lost.
- R11: If an expiry and a clearing write to the status register fall in the same cycle, the pending flag ends up set.
- R12: Only bit 8 of the run register at offset 0x14 switches counting on. Other bits of that register are neither stored nor acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Alarm interrupt, level |

## Verification
Two pairs of events can land in one clock cycle. The first pair is the expiry tick and a clearing write to the status register. The second pair is a counted tick and a write to the interval register. The bench drives the tick and the bus write on the same cycle edge. For the first pair it then expects the pending flag to remain set. For the second pair it expects the freshly written interval, with no second subtracted. The borrow chain is swept over combinations of 0, 1 and the top value in each field, and every result is compared with an interval rebuilt from a plain seconds total.

// File: rtl/ralarm_pkg.sv
package ralarm_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;
  localparam int DAY_W   = 8;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = HR_LSB + HR_W;

  localparam logic [ADDR_W-1:0] OFF_SPAN = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFF_RUN  = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] OFF_IEN  = ADDR_W'(5'h18);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(5'h1C);

  localparam int RUN_BIT  = 8;
  localparam int IEN_BIT  = 0;
  localparam int PEND_BIT = 0;

  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(23);

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } span_t;

  localparam int SPAN_W = $bits(span_t);

  function automatic span_t span_from_word(input logic [DATA_W-1:0] w);
    span_t s;
    s.sec = w[SEC_LSB +: SEC_W];
    s.min = w[MIN_LSB +: MIN_W];
    s.hr  = w[HR_LSB  +: HR_W];
    s.day = w[DAY_LSB +: DAY_W];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] span_to_word(input span_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = s.sec;
    w[MIN_LSB +: MIN_W] = s.min;
    w[HR_LSB  +: HR_W]  = s.hr;
    w[DAY_LSB +: DAY_W] = s.day;
    return w;
  endfunction

  function automatic logic span_is_last(input span_t s);
    return s == span_t'({{(SPAN_W-1){1'b0}}, 1'b1});
  endfunction

  // one second less, borrowing upward through the fields
  function automatic span_t span_step(input span_t s);
    span_t n;
    n = s;
    if (s.sec != '0) begin
      n.sec = s.sec - SEC_W'(1);
    end else begin
      n.sec = SEC_TOP;
      if (s.min != '0) begin
        n.min = s.min - MIN_W'(1);
      end else begin
        n.min = MIN_TOP;
        if (s.hr != '0) begin
          n.hr = s.hr - HR_W'(1);
        end else begin
          n.hr  = HR_TOP;
          n.day = s.day - DAY_W'(1);
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/ralarm_bus_decode.sv
module ralarm_bus_decode
  import ralarm_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  span_t             span,
  input  logic              run,
  input  logic              ien,
  input  logic              pend,
  output logic              wr_span,
  output logic              wr_run,
  output logic              wr_ien,
  output logic              wr_stat,
  output span_t             load_span,
  output logic              run_bit,
  output logic              ien_bit,
  output logic              clr_bit,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr_any;
  logic rd_any;
  logic unused_wbits;

  assign wr_any  = bus_sel && bus_wr;
  assign rd_any  = bus_sel && !bus_wr;
  assign wr_span = wr_any && (bus_addr == OFF_SPAN);
  assign wr_run  = wr_any && (bus_addr == OFF_RUN);
  assign wr_ien  = wr_any && (bus_addr == OFF_IEN);
  assign wr_stat = wr_any && (bus_addr == OFF_STAT);

  assign load_span = span_from_word(bus_wdata);
  assign run_bit   = bus_wdata[RUN_BIT];
  assign ien_bit   = bus_wdata[IEN_BIT];
  assign clr_bit   = bus_wdata[PEND_BIT];
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (bus_addr)
        OFF_SPAN: bus_rdata = span_to_word(span);
        OFF_RUN:  bus_rdata[RUN_BIT]  = run;
        OFF_IEN:  bus_rdata[IEN_BIT]  = ien;
        OFF_STAT: bus_rdata[PEND_BIT] = pend;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ralarm_span_counter.sv
module ralarm_span_counter
  import ralarm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  load,
  input  span_t load_span,
  output span_t span,
  output logic  zero,
  output logic  expire
);
  span_t span_q;
  span_t span_next;
  logic  count_ok;

  assign zero     = (span_q == '0);
  assign count_ok = step && !load && !zero;
  assign expire   = count_ok && span_is_last(span_q);
  assign span     = span_q;

  always_comb begin
    span_next = span_q;
    if (load)          span_next = load_span;
    else if (count_ok) span_next = span_step(span_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) span_q <= '0;
    else        span_q <= span_next;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(span_q)); // R3
  AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R6
  AST_EXPIRE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> zero); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (span_q == $past(load_span))); // R10
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ok && span_q.sec == '0) |=> (span_q.sec == SEC_TOP)); // R4
endmodule

// File: rtl/ralarm_ctrl_regs.sv
module ralarm_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_run,
  input  logic run_bit,
  input  logic wr_ien,
  input  logic ien_bit,
  input  logic wr_stat,
  input  logic clr_bit,
  input  logic expire,
  output logic run,
  output logic ien,
  output logic pend,
  output logic irq
);
  logic clr_req;

  assign clr_req = wr_stat && clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      ien  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (wr_run) run <= run_bit;
      if (wr_ien) ien <= ien_bit;
      if (expire)       pend <= 1'b1;
      else if (clr_req) pend <= 1'b0;
    end
  end

  assign irq = pend && ien;

  AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend); // R11
  AST_PEND_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(clr_req)); // R7
endmodule

// File: rtl/rel_alarm.sv
module rel_alarm
  import ralarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic  wr_span, wr_run, wr_ien, wr_stat;
  logic  run_bit, ien_bit, clr_bit;
  logic  run, ien, pend;
  logic  step, zero, expire;
  span_t load_span;
  span_t span;

  assign step = tick_1hz && run;

  ralarm_bus_decode u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .span      (span),
    .run       (run),
    .ien       (ien),
    .pend      (pend),
    .wr_span   (wr_span),
    .wr_run    (wr_run),
    .wr_ien    (wr_ien),
    .wr_stat   (wr_stat),
    .load_span (load_span),
    .run_bit   (run_bit),
    .ien_bit   (ien_bit),
    .clr_bit   (clr_bit),
    .bus_rdata (bus_rdata)
  );

  ralarm_span_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load      (wr_span),
    .load_span (load_span),
    .span      (span),
    .zero      (zero),
    .expire    (expire)
  );

  ralarm_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_run  (wr_run),
    .run_bit (run_bit),
    .wr_ien  (wr_ien),
    .ien_bit (ien_bit),
    .wr_stat (wr_stat),
    .clr_bit (clr_bit),
    .expire  (expire),
    .run     (run),
    .ien     (ien),
    .pend    (pend),
    .irq     (irq)
  );

  AST_NO_EXPIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |-> !expire); // R3
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq)) |-> (ien && pend)); // R8
endmodule

// File: tb/sim_rel_alarm.sv
module sim_rel_alarm;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_SPAN = 5'h0C;
  localparam logic [4:0] A_RUN  = 5'h14;
  localparam logic [4:0] A_IEN  = 5'h18;
  localparam logic [4:0] A_STAT = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rel_alarm u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic int total(int d, int h, int m, int s);
    return ((d * 24 + h) * 60 + m) * 60 + s;
  endfunction

  function automatic logic [31:0] from_total(int t);
    return pack(t / 86400, (t / 3600) % 24, (t / 60) % 60, t % 60);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic wr_with_tick(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_1hz = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int t0;
    int vs[3];
    int vm[3];
    int vh[3];
    int vd[3];
    vs = '{0, 1, 59}; vm = '{0, 1, 59}; vh = '{0, 1, 23}; vd = '{0, 1, 255};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_SPAN, r); chk("R1 span", r, 0);
    rd(A_RUN, r);  chk("R1 run", r, 0);
    rd(A_IEN, r);  chk("R1 ien", r, 0);
    rd(A_STAT, r); chk("R1 stat", r, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 readback, unused bits dropped
    wr(A_SPAN, pack(200, 17, 42, 9) | 32'hE000_C0C0);
    rd(A_SPAN, r); chk("R2 span readback", r, pack(200, 17, 42, 9));
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, r); chk("R2 ien readback", r, 32'h1);
    wr(A_IEN, 0);

    // R12 wrong run bit does not start counting; R3 ticks ignored
    wr(A_RUN, 32'hFFFF_FEFF);
    rd(A_RUN, r); chk("R12 run reg", r, 0);
    ticks(3);
    rd(A_SPAN, r); chk("R3 stopped", r, pack(200, 17, 42, 9));
    wr(A_RUN, 32'h100);
    rd(A_RUN, r); chk("R12 run set", r, 32'h100);
    repeat (5) @(negedge clk);
    rd(A_SPAN, r); chk("R3 no tick", r, pack(200, 17, 42, 9));
    ticks(1);
    rd(A_SPAN, r); chk("R3 one tick", r, pack(200, 17, 42, 8));

    // R4 borrow sweep
    foreach (vd[id]) foreach (vh[ih]) foreach (vm[im]) foreach (vs[is]) begin
      t0 = total(vd[id], vh[ih], vm[im], vs[is]);
      wr(A_RUN, 0);
      wr(A_SPAN, pack(vd[id], vh[ih], vm[im], vs[is]));
      wr(A_RUN, 32'h100);
      ticks(2);
      rd(A_SPAN, r);
      chk("R4 borrow", r, from_total(t0 >= 2 ? t0 - 2 : 0));
      rd(A_STAT, r);
      chk("R5 R6 flag after sweep step", r, (t0 >= 1 && t0 <= 2) ? 1 : 0);
      wr(A_STAT, 1);
    end

    // R5 exact expiry, R8 irq gating
    wr(A_RUN, 0);
    wr(A_SPAN, pack(0, 0, 2, 3));
    wr(A_RUN, 32'h100);
    ticks(122);
    rd(A_SPAN, r); chk("R5 one left", r, pack(0, 0, 0, 1));
    rd(A_STAT, r); chk("R5 not yet", r, 0);
    ticks(1);
    rd(A_STAT, r); chk("R5 expired", r, 1);
    rd(A_SPAN, r); chk("R5 zero", r, 0);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(A_IEN, 1);
    chk("R8 irq on", {31'b0, irq}, 1);
    ticks(4);
    rd(A_SPAN, r); chk("R6 stays zero", r, 0);
    wr(A_STAT, 0);
    rd(A_STAT, r); chk("R7 write zero keeps", r, 1);
    wr(A_STAT, 1);
    rd(A_STAT, r); chk("R7 cleared", r, 0);
    chk("R8 irq off", {31'b0, irq}, 0);
    ticks(4);
    rd(A_STAT, r); chk("R6 no re-set", r, 0);

    // R9 cancel by zero load
    wr(A_SPAN, pack(0, 0, 0, 5));
    ticks(2);
    wr(A_SPAN, 0);
    ticks(8);
    rd(A_STAT, r); chk("R9 no expiry", r, 0);
    chk("R9 irq", {31'b0, irq}, 0);

    // R10 load wins over tick
    wr(A_SPAN, pack(0, 0, 0, 5));
    wr_with_tick(A_SPAN, pack(0, 0, 0, 30));
    rd(A_SPAN, r); chk("R10 load wins", r, pack(0, 0, 0, 30));

    // R11 expiry and clear together
    wr(A_SPAN, pack(0, 0, 0, 1));
    wr_with_tick(A_STAT, 1);
    rd(A_STAT, r); chk("R11 set wins", r, 1);
    chk("R11 irq", {31'b0, irq}, 1);
    wr(A_STAT, 1);
    rd(A_STAT, r); chk("R7 clear after", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule